// File: doc/BRIEF.md
# Word-Parallel Ethernet Frame Check Sequence Generator

This block computes the 32-bit Ethernet frame check sequence over a frame that arrives eight bytes per clock on a 64-bit word. Each accepted word moves the 32-bit remainder forward by all 64 bits in a single cycle. The final word of a frame may carry anywhere from one to eight meaningful bytes. For that word a separate update network, sized to the byte count, produces the closing remainder.

The register is loaded with all ones on the first word of a frame. The closing remainder is complemented and presented, registered, one cycle after the last word has been accepted, together with a one-cycle completion strobe. Framing, preamble handling and placing the check bytes into the outgoing stream are done by the surrounding logic.

Top module: `crc32_tail_enc`

## Requirements
- R1: After reset, `done_o` is 0 and `fcs_o` is 0.
- R2: The generator is 0x04C11DB7, with the x^32 term implicit. Data enters most-significant bit first. With preset and output complement both set to zero, the two-byte message 0x95 then 0x95 gives 0x3738F30B.
- R3: A word with `valid_i` and `sof_i` high starts from an all-ones remainder, whatever the register held before. A valid word with `sof_i` low continues from the register.
- R4: A valid word with `eop_i` low advances the remainder over all eight bytes. Lane 0 (`data_i[7:0]`) is first in time and lane 7 (`data_i[63:56]`) is last.
- R5: On a valid word with `eop_i` high, `bcnt_i` values 1 to 7 select that many bytes from lane 0 upward. A value of 8, or 0, or any value above 8, selects all eight lanes. Bytes in lanes at or above the count have no effect on `fcs_o`.
- R6: One cycle after a valid word with `eop_i` high, `done_o` is 1 for exactly that cycle. In the same cycle, `fcs_o` shows the bitwise complement of the final remainder.
- R7: While `valid_i` is low, the remainder register keeps its value. `data_i`, `sof_i`, `eop_i` and `bcnt_i` are ignored in those cycles.
- R8: On valid words with `eop_i` low, `bcnt_i` has no effect.
- R9: A one-byte frame is handled correctly, and so is a frame whose length is a multiple of eight bytes.
- R10: Twelve bytes, BE D7 23 47 6B 8F B3 14 5E FB 35 59, sent 126 times as one frame, give the same `fcs_o` as a bit-serial computation.
- R11: `fcs_o` keeps its value in every cycle in which `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word on `data_i` is accepted this cycle |
| sof_i | input | 1 | First word of a frame |
| eop_i | input | 1 | Last word of a frame |
| bcnt_i | input | 4 | Valid bytes in the last word (1 to 8) |
| data_i | input | 64 | Frame bytes, lane 0 first |
| fcs_o | output | 32 | Complemented remainder of the last frame |
| done_o | output | 1 | One-cycle strobe when `fcs_o` is updated |

## Verification
Start and end of frame can fall in the same cycle in two ways. The first is a frame of eight bytes or fewer, where one word carries both `sof_i` and `eop_i`. The second is back-to-back frames, where the completion strobe of one frame comes in the cycle that accepts the first word of the next. The bench sends lengths 1 through 17 with no idle cycles between them, which produces both cases repeatedly. A behavioural model computes the expected check value bit by bit, and that value is compared with `done_o` and `fcs_o` on every clock. A stale remainder carried across a frame boundary, or a late strobe, therefore appears as a miscompare.

// File: rtl/crc32_tail_pkg.sv
package crc32_tail_pkg;

   localparam int CRC_W      = 32;
   localparam int MAX_DATA_W = 64;
   localparam int BYTE_W     = 8;

   typedef logic [CRC_W-1:0] crc_t;

   // Advance a remainder over the first nbytes bytes of data, byte 0 first,
   // each byte most-significant bit first (shift-left division).
   function automatic crc_t crc_advance(crc_t crc, logic [MAX_DATA_W-1:0] data,
                                        int nbytes, crc_t poly);
      crc_t r;
      logic fb;
      r = crc;
      for (int b = 0; b < MAX_DATA_W/BYTE_W; b++) begin
         if (b < nbytes) begin
            for (int i = BYTE_W-1; i >= 0; i--) begin
               fb = r[CRC_W-1] ^ data[b*BYTE_W+i];
               r  = {r[CRC_W-2:0], 1'b0};
               if (fb) r = r ^ poly;
            end
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/crc32_lane_net.sv
module crc32_lane_net
   import crc32_tail_pkg::*;
#(
   parameter int   NBYTES = 8,
   parameter crc_t POLY   = 32'h04C11DB7,
   localparam int  IN_W   = NBYTES*BYTE_W
) (
   input  logic            en_i,
   input  crc_t            crc_i,
   input  logic [IN_W-1:0] data_i,
   output crc_t            crc_o
);

   logic [MAX_DATA_W-1:0] data_iso;
   crc_t                  crc_iso;

   // Operand isolation: a disabled network sees constant zero inputs.
   always_comb begin
      data_iso = '0;
      crc_iso  = '0;
      if (en_i) begin
         data_iso[IN_W-1:0] = data_i;
         crc_iso            = crc_i;
      end
   end

   assign crc_o = crc_advance(crc_iso, data_iso, NBYTES, POLY);

endmodule

// File: rtl/crc32_tail_mux.sv
module crc32_tail_mux
   import crc32_tail_pkg::*;
#(
   parameter int  LANES = 8,
   localparam int CNT_W = $clog2(LANES+1)
) (
   input  logic [LANES-1:0][CRC_W-1:0] cand_i,
   input  logic [CNT_W-1:0]            used_i,
   output crc_t                        crc_o
);

   always_comb begin
      crc_o = cand_i[LANES-1];
      for (int k = 0; k < LANES-1; k++) begin
         if (used_i == CNT_W'(k+1)) crc_o = cand_i[k];
      end
   end

endmodule

// File: rtl/crc32_tail_enc.sv
module crc32_tail_enc
   import crc32_tail_pkg::*;
#(
   parameter int   DATA_W  = 64,
   parameter int   LANE_W  = 8,
   parameter crc_t POLY    = 32'h04C11DB7,
   parameter crc_t INIT    = 32'hFFFFFFFF,
   parameter crc_t XOR_OUT = 32'hFFFFFFFF,
   localparam int  LANES   = DATA_W/LANE_W,
   localparam int  CNT_W   = $clog2(LANES+1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic              sof_i,
   input  logic              eop_i,
   input  logic [CNT_W-1:0]  bcnt_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  fcs_o,
   output logic              done_o
);

   if (LANE_W != BYTE_W) begin : g_bad_lane
      $error("LANE_W must be one byte");
   end
   if (DATA_W % LANE_W != 0) begin : g_bad_div
      $error("DATA_W must be a whole number of lanes");
   end
   if (DATA_W > MAX_DATA_W) begin : g_bad_wide
      $error("DATA_W exceeds package limit");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("at least two lanes required");
   end

   crc_t                        crc_q;
   crc_t                        fcs_q;
   logic                        done_q;
   crc_t                        base;
   crc_t                        next;
   logic [CNT_W-1:0]            used;
   logic [LANES-1:0][CRC_W-1:0] cand;
   logic [LANES-2:0]            narrow_en;

   assign base = sof_i ? INIT : crc_q;

   // Lanes consumed this word: honour the count only on the closing word.
   always_comb begin
      used = CNT_W'(LANES);
      if (eop_i && (bcnt_i != '0) && (bcnt_i < CNT_W'(LANES))) used = bcnt_i;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_net
      logic en;
      if (k == LANES-1) begin : g_full
         assign en = valid_i;
      end else begin : g_tail
         assign en           = valid_i && eop_i && (used == CNT_W'(k+1));
         assign narrow_en[k] = en;
      end
      crc32_lane_net #(
         .NBYTES(k+1),
         .POLY  (POLY)
      ) u_net (
         .en_i  (en),
         .crc_i (base),
         .data_i(data_i[(k+1)*LANE_W-1:0]),
         .crc_o (cand[k])
      );
   end

   crc32_tail_mux #(
      .LANES(LANES)
   ) u_mux (
      .cand_i(cand),
      .used_i(used),
      .crc_o (next)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crc_q  <= '0;
         fcs_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= valid_i && eop_i;
         if (valid_i) crc_q <= next;
         if (valid_i && eop_i) fcs_q <= next ^ XOR_OUT;
      end
   end

   assign fcs_o  = fcs_q;
   assign done_o = done_q;

endmodule

// File: rtl/crc32_tail_chk.sv
module crc32_tail_chk #(
   parameter int LANES = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             valid_i,
   input logic             eop_i,
   input logic             done_i,
   input logic [31:0]      fcs_i,
   input logic [31:0]      state_i,
   input logic [LANES-2:0] narrow_en_i
);

   // R6
   done_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && eop_i) |=> done_i);

   // R6
   done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> $past(valid_i && eop_i));

   // R11
   fcs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i |-> $stable(fcs_i));

   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(state_i));

   // R5
   narrow_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(narrow_en_i));

   // R8
   narrow_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !eop_i) |-> (narrow_en_i == '0));

endmodule

bind crc32_tail_enc crc32_tail_chk #(.LANES(LANES)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .valid_i    (valid_i),
   .eop_i      (eop_i),
   .done_i     (done_o),
   .fcs_i      (fcs_o),
   .state_i    (crc_q),
   .narrow_en_i(narrow_en)
);

// File: tb/sim_crc32_tail_enc.sv
`timescale 1ns/1ps
module sim_crc32_tail_enc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic        sof = 1'b0;
   logic        eop = 1'b0;
   logic [3:0]  bcnt = '0;
   logic [63:0] data = '0;
   logic [31:0] fcs, fcs_p;
   logic        done, done_p;

   always #2.5 clk = ~clk;

   crc32_tail_enc u0 (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eop_i(eop),
      .bcnt_i(bcnt), .data_i(data), .fcs_o(fcs), .done_o(done)
   );

   // Plain configuration: zero preset, no output complement (R2).
   crc32_tail_enc #(.INIT(32'h0), .XOR_OUT(32'h0)) u1 (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof), .eop_i(eop),
      .bcnt_i(bcnt), .data_i(data), .fcs_o(fcs_p), .done_o(done_p)
   );

   int          vectors = 0;
   int          miscompares = 0;
   string       cur_req = "R1";
   bit          cmp_on = 1'b0;
   logic        exp_done = 1'b0;
   logic [31:0] exp_fcs = '0;

   function automatic logic [31:0] ref_crc(logic [7:0] q[$], logic [31:0] init,
                                           logic [31:0] xo);
      logic [31:0] r;
      logic        t;
      r = init;
      foreach (q[n]) begin
         for (int i = 7; i >= 0; i--) begin
            t = r[31] ^ q[n][i];
            r = r << 1;
            if (t) r = r ^ 32'h04C11DB7;
         end
      end
      return r ^ xo;
   endfunction

   always @(negedge clk) begin
      if (cmp_on) begin
         vectors++;
         if (done !== exp_done || fcs !== exp_fcs) begin
            miscompares++;
            $display("FAIL %s: done=%0b fcs=%h expected done=%0b fcs=%h",
                     cur_req, done, fcs, exp_done, exp_fcs);
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      valid = 1'b0;
      data  = {$urandom, $urandom};
      sof   = 1'($urandom);
      eop   = 1'($urandom);
      bcnt  = 4'($urandom);
      @(posedge clk);
      exp_done = 1'b0;
   endtask

   task automatic send_frame(logic [7:0] q[$], int gap);
      int n;
      int nw;
      n  = q.size();
      nw = (n + 7) / 8;
      for (int w = 0; w < nw; w++) begin
         @(negedge clk);
         valid = 1'b1;
         sof   = (w == 0);
         eop   = (w == nw-1);
         data  = {$urandom, $urandom};
         for (int l = 0; l < 8; l++)
            if (w*8 + l < n) data[l*8 +: 8] = q[w*8 + l];
         bcnt = eop ? 4'(n - w*8) : 4'($urandom);
         @(posedge clk);
         exp_done = eop;
         if (eop) exp_fcs = ref_crc(q, 32'hFFFFFFFF, 32'hFFFFFFFF);
         if (w != nw-1) repeat (gap) idle();
      end
   endtask

   task automatic rand_frame(int len, int gap);
      logic [7:0] q[$];
      for (int i = 0; i < len; i++) q.push_back(8'($urandom));
      send_frame(q, gap);
   endtask

   initial begin
      #(5.0 * 150000);
      miscompares++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] q[$];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      vectors++;
      if (done !== 1'b0 || fcs !== 32'h0) begin
         miscompares++;
         $display("FAIL R1: done=%0b fcs=%h expected done=0 fcs=00000000", done, fcs);
      end
      cmp_on = 1'b1;

      // R2: generator and bit order on the plain instance
      cur_req = "R2";
      q = '{8'h95, 8'h95};
      send_frame(q, 0);
      @(negedge clk);
      vectors++;
      if (done_p !== 1'b1 || fcs_p !== 32'h3738F30B) begin
         miscompares++;
         $display("FAIL R2: done=%0b fcs=%h expected done=1 fcs=3738f30b", done_p, fcs_p);
      end

      // R5 R9 R3: every tail length, back to back
      cur_req = "R5";
      for (int len = 1; len <= 17; len++) rand_frame(len, 0);

      // R9: multiples of eight, single byte
      cur_req = "R9";
      rand_frame(8, 0);
      rand_frame(16, 0);
      rand_frame(1, 0);
      rand_frame(24, 1);

      // R7 R8: idle cycles with noise inside a frame, random counts mid-frame
      cur_req = "R7";
      rand_frame(64, 2);
      rand_frame(13, 3);
      repeat (4) idle();

      // R4 R3: long frames, restart without reset
      cur_req = "R4";
      rand_frame(200, 0);
      rand_frame(77, 1);

      // R10: 126 repetitions of the 12-byte pattern
      cur_req = "R10";
      q = {};
      for (int r = 0; r < 126; r++)
         q = {q, 8'hBE, 8'hD7, 8'h23, 8'h47, 8'h6B, 8'h8F,
                 8'hB3, 8'h14, 8'h5E, 8'hFB, 8'h35, 8'h59};
      send_frame(q, 0);

      // R11: output held across idle cycles
      cur_req = "R11";
      repeat (6) idle();

      @(negedge clk);
      cmp_on = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule